// File: doc/BRIEF.md
# Column Drive Latch with Override Priority and Dead-Time Sequencing

This block sits between a column shift loader and a bank of high-voltage push-pull output stages. It holds one bit per column, captured from the loader's parallel word while the capture enable is high and held while it is low. A few global controls select what each column drives: polarity, an output enable, an active-low force-low and an active-low force-high. Their priority is fixed. A disabled output stage floats every column. Force-low beats force-high, and force-high beats the data, which polarity may invert.

Each column has a small sequencer that turns its drive target into two gate enables: pull-up and pull-down. When a column stops driving, the sequencer holds both enables off for a programmable number of cycles before either may turn on again. The two transistors of a column therefore never conduct together, and they never switch straight from one to the other.

The column sequencer has four states. ST_IDLE holds both enables off with no pending gap. ST_UP drives high and ST_DN drives low. ST_GAP is the break interval, with both enables off.

Its transitions are:
- IDLE to UP or to DN, on the next edge, when the target is high or low.
- UP or DN to GAP when the target differs from what is being driven. The gap counter loads 1.
- GAP to UP, DN or IDLE when the counter has reached the programmed dead count, chosen from the target in that cycle.
- GAP to GAP otherwise, with the counter incremented.

Top module: `colmode_top`

## Requirements
- R1: On each rising clock edge with `le` high, the stored column word takes the value of `din`. With `le` low, the stored word is unchanged whatever `din` does.
- R2: While `rst_n` is low, all stored bits are 0 and every `pu_en`/`pd_en` bit is 0. After release, the stored word stays 0 until a capture.
- R3: If `out_en` is sampled low at an edge, every column shows `pu_en`=0 and `pd_en`=0 after that edge, whatever the other controls and data are.
- R4: With `out_en` high and `force_lo_n` low, every column targets low, whatever `pol` and `force_hi_n` are. No `pu_en` bit is 1 after such an edge.
- R5: With `out_en` high, `force_lo_n` high and `force_hi_n` low, every column targets high. No `pd_en` bit is 1 after such an edge.
- R6: With `out_en`, `force_lo_n` and `force_hi_n` all high, a column targets high when its stored bit equals `pol`, and low otherwise. `pol`=1 means the column follows the bit, `pol`=0 means it follows the inverse.
- R7: The per-column encoding of {`pu_en`,`pd_en`} is 00 for floating, 10 for driving high and 01 for driving low. The code 11 never appears.
- R8: When a driving column leaves its state, both enables are 0 for exactly max(`dead_cycles`,1) cycles before either enable may assert. No enable rises in the cycle after the opposite one was 1.
- R9: From the floating idle state, a high or low target drives the column on the next edge, with no gap.
- R10: At the end of a gap, the column adopts the target present in that cycle: high, low or idle. Target changes during the gap do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| le | input | 1 | Capture enable for the column word |
| din | input | N_COL | Parallel column word from the loader |
| pol | input | 1 | 1: drive follows stored bit, 0: inverted |
| out_en | input | 1 | 0 floats every column |
| force_lo_n | input | 1 | Active-low force of every column low |
| force_hi_n | input | 1 | Active-low force of every column high |
| dead_cycles | input | DEAD_W | Break-before-make interval in cycles (0 treated as 1) |
| pu_en | output | N_COL | Per-column pull-up gate enable |
| pd_en | output | N_COL | Per-column pull-down gate enable |

## Verification
Override changes can arrive while columns are still inside a break gap. A capture of new data can also coincide with a change of polarity or override. Random stimulus provokes both, and the dead count is sometimes altered mid-gap. A cycle-accurate bench model of the priority and gap rules predicts both enable vectors after every edge. Directed cases cover all 16 control combinations, an exact gap length of three cycles and the gap-free start from the floating state.

// File: rtl/colmode_pkg.sv
package colmode_pkg;

    typedef enum logic [1:0] {
        TGT_Z  = 2'b00,
        TGT_HI = 2'b01,
        TGT_LO = 2'b10
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DN   = 2'b10,
        ST_GAP  = 2'b11
    } bbm_state_e;

endpackage

// File: rtl/col_latch.sv
module col_latch #(
    parameter int N_COL = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [N_COL-1:0] din,
    output logic [N_COL-1:0] q
);

    // Clocked transparency: the word is refreshed every edge while le is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (le) begin
            q <= din;
        end
    end

endmodule

// File: rtl/col_target.sv
module col_target
    import colmode_pkg::*;
#(
    parameter int N_COL = 96
) (
    input  logic [N_COL-1:0] q,
    input  logic             pol,
    input  logic             out_en,
    input  logic             force_lo_n,
    input  logic             force_hi_n,
    output tgt_e             tgt [N_COL]
);

    // Fixed priority: float, force low, force high, polarity-adjusted data.
    always_comb begin
        for (int c = 0; c < N_COL; c++) begin
            if (!out_en) begin
                tgt[c] = TGT_Z;
            end else if (!force_lo_n) begin
                tgt[c] = TGT_LO;
            end else if (!force_hi_n) begin
                tgt[c] = TGT_HI;
            end else if (q[c] == pol) begin
                tgt[c] = TGT_HI;
            end else begin
                tgt[c] = TGT_LO;
            end
        end
    end

endmodule

// File: rtl/col_bbm.sv
module col_bbm
    import colmode_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_e              tgt,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              pu,
    output logic              pd
);

    localparam logic [DEAD_W-1:0] CNT_ONE = DEAD_W'(1);

    bbm_state_e        state_q, state_d;
    logic [DEAD_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tgt == TGT_HI) begin
                    state_d = ST_UP;
                end else if (tgt == TGT_LO) begin
                    state_d = ST_DN;
                end
            end
            ST_UP: begin
                if (tgt != TGT_HI) begin
                    state_d = ST_GAP;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_DN: begin
                if (tgt != TGT_LO) begin
                    state_d = ST_GAP;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_GAP: begin
                if (cnt_q >= dead_cycles) begin
                    if (tgt == TGT_HI) begin
                        state_d = ST_UP;
                    end else if (tgt == TGT_LO) begin
                        state_d = ST_DN;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        pu = (state_q == ST_UP);
        pd = (state_q == ST_DN);
    end

endmodule

// File: rtl/colmode_top.sv
module colmode_top
    import colmode_pkg::*;
#(
    parameter int N_COL  = 96,
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [N_COL-1:0]  din,
    input  logic              pol,
    input  logic              out_en,
    input  logic              force_lo_n,
    input  logic              force_hi_n,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic [N_COL-1:0]  pu_en,
    output logic [N_COL-1:0]  pd_en
);

    logic [N_COL-1:0] lat_q;
    tgt_e             tgt [N_COL];

    col_latch #(.N_COL(N_COL)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .din   (din),
        .q     (lat_q)
    );

    col_target #(.N_COL(N_COL)) u_tgt (
        .q          (lat_q),
        .pol        (pol),
        .out_en     (out_en),
        .force_lo_n (force_lo_n),
        .force_hi_n (force_hi_n),
        .tgt        (tgt)
    );

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        col_bbm #(.DEAD_W(DEAD_W)) u_bbm (
            .clk         (clk),
            .rst_n       (rst_n),
            .tgt         (tgt[c]),
            .dead_cycles (dead_cycles),
            .pu          (pu_en[c]),
            .pd          (pd_en[c])
        );
    end

endmodule

// File: rtl/colmode_chk.sv
module colmode_chk #(
    parameter int N_COL = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             le,
    input logic             out_en,
    input logic             force_lo_n,
    input logic             force_hi_n,
    input logic [N_COL-1:0] lat_q,
    input logic [N_COL-1:0] pu_en,
    input logic [N_COL-1:0] pd_en
);

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(lat_q)); // R1

    AST_FLOAT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (pu_en == '0 && pd_en == '0)); // R3

    AST_NO_PULLUP_ON_FORCE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !force_lo_n) |=> (pu_en == '0)); // R4

    AST_NO_PULLDN_ON_FORCE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && force_lo_n && !force_hi_n) |=> (pd_en == '0)); // R5

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & pd_en) == '0); // R7

    AST_GAP_BEFORE_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & $past(pd_en)) == '0); // R8

    AST_GAP_BEFORE_PULLDN: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & $past(pu_en)) == '0); // R8

endmodule

bind colmode_top colmode_chk #(.N_COL(N_COL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .le         (le),
    .out_en     (out_en),
    .force_lo_n (force_lo_n),
    .force_hi_n (force_hi_n),
    .lat_q      (lat_q),
    .pu_en      (pu_en),
    .pd_en      (pd_en)
);

// File: tb/colmode_top_tb.sv
module colmode_top_tb;

    localparam int N = 96;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          le = 1'b0;
    logic [N-1:0]  din = '0;
    logic          pol = 1'b1;
    logic          out_en = 1'b0;
    logic          force_lo_n = 1'b1;
    logic          force_hi_n = 1'b1;
    logic [DW-1:0] dead_cycles = 4'd2;
    logic [N-1:0]  pu_en, pd_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    colmode_top #(.N_COL(N), .DEAD_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .le(le), .din(din), .pol(pol),
        .out_en(out_en), .force_lo_n(force_lo_n), .force_hi_n(force_hi_n),
        .dead_cycles(dead_cycles), .pu_en(pu_en), .pd_en(pd_en)
    );

    // Target per requirements: 0 float, 1 high, 2 low
    function automatic int tgt_of(logic oe, logic fl_n, logic fh_n, logic p, logic b);
        if (!oe) return 0;
        if (!fl_n) return 2;
        if (!fh_n) return 1;
        return (b == p) ? 1 : 2;
    endfunction

    // Reference model of sequencing (R8, R9, R10)
    int unsigned  ms [N];
    int unsigned  mc [N];
    logic [N-1:0] mlat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin ms[c] = 0; mc[c] = 0; end
            mlat = '0;
        end else begin
            for (int c = 0; c < N; c++) begin
                int t;
                t = tgt_of(out_en, force_lo_n, force_hi_n, pol, mlat[c]);
                case (ms[c])
                    0: if (t == 1) ms[c] = 1; else if (t == 2) ms[c] = 2;
                    1: if (t != 1) begin ms[c] = 3; mc[c] = 1; end
                    2: if (t != 2) begin ms[c] = 3; mc[c] = 1; end
                    default: begin
                        if (mc[c] >= int'(dead_cycles)) ms[c] = (t == 1) ? 1 : (t == 2) ? 2 : 0;
                        else mc[c] = mc[c] + 1;
                    end
                endcase
            end
            if (le) mlat = din;
        end
    end

    task automatic chk(string tag, logic [N-1:0] apu, logic [N-1:0] epu,
                       logic [N-1:0] apd, logic [N-1:0] epd);
        checks++;
        if (apu !== epu || apd !== epd) begin
            errors++;
            $display("FAIL %s: pu=%h exp %h, pd=%h exp %h", tag, apu, epu, apd, epd);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [N-1:0] rnd_word();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic expect_steady(string tag, logic [N-1:0] data);
        logic [N-1:0] epu, epd;
        for (int c = 0; c < N; c++) begin
            int t;
            t = tgt_of(out_en, force_lo_n, force_hi_n, pol, data[c]);
            epu[c] = (t == 1);
            epd[c] = (t == 2);
        end
        chk(tag, pu_en, epu, pd_en, epd);
    endtask

    initial begin
        logic [N-1:0] pat_a, pat_b;
        int zeros;
        void'($urandom(32'd7321));

        // R2: reset state
        step(3);
        chk("R2 reset", pu_en, '0, pd_en, '0);
        rst_n = 1'b1;
        out_en = 1'b1;
        step(1);
        chk("R2 cleared word drives low", pu_en, '0, pd_en, '1);

        // R1: capture then hold
        pat_a = rnd_word();
        din = pat_a; le = 1'b1;
        step(1);
        le = 1'b0; din = ~pat_a;
        step(6);
        expect_steady("R1 hold pol=1", pat_a);
        chk("R6 follow bit", pu_en, pat_a, pd_en, ~pat_a);
        pol = 1'b0;
        step(6);
        chk("R6 inverted bit", pu_en, ~pat_a, pd_en, pat_a);

        // R3-R6: all 16 control combinations
        for (int k = 0; k < 16; k++) begin
            out_en = k[3]; force_lo_n = k[2]; force_hi_n = k[1]; pol = k[0];
            step(1);
            if (!out_en) chk("R3 float next edge", pu_en, '0, pd_en, '0);
            step(6);
            if (!out_en) expect_steady("R3 combo", pat_a);
            else if (!force_lo_n) expect_steady("R4 combo", pat_a);
            else if (!force_hi_n) expect_steady("R5 combo", pat_a);
            else expect_steady("R6 combo", pat_a);
        end

        // R8: exact gap of 3 cycles from high to low
        dead_cycles = 4'd3;
        out_en = 1'b1; force_lo_n = 1'b1; force_hi_n = 1'b0;
        step(6);
        chk("R5 all high", pu_en, '1, pd_en, '0);
        force_lo_n = 1'b0;
        zeros = 0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (pu_en == '0 && pd_en == '0) zeros++;
            else break;
        end
        checks++;
        if (zeros != 3) begin
            errors++;
            $display("FAIL R8 gap length: %0d exp %0d", zeros, 3);
        end
        chk("R8 low after gap", pu_en, '0, pd_en, '1);

        // R8 with dead count 0 acts as one cycle
        dead_cycles = 4'd0;
        force_lo_n = 1'b1;
        step(1);
        chk("R8 zero dead gap", pu_en, '0, pd_en, '0);
        step(1);
        chk("R8 zero dead end", pu_en, '1, pd_en, '0);

        // R9: from idle float straight to drive
        out_en = 1'b0;
        step(4);
        out_en = 1'b1;
        step(1);
        chk("R9 no gap from idle", pu_en, '1, pd_en, '0);

        // R10 and R7: random stimulus against model
        pat_b = '0;
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] epu, epd;
            int r;
            r = $urandom_range(0, 99);
            out_en = (r >= 8);
            force_lo_n = ($urandom_range(0, 9) != 0);
            force_hi_n = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 7) == 0) pol = ~pol;
            le = ($urandom_range(0, 3) == 0);
            din = rnd_word();
            if ($urandom_range(0, 31) == 0) dead_cycles = DW'($urandom_range(0, 5));
            step(1);
            for (int c = 0; c < N; c++) begin
                epu[c] = (ms[c] == 1);
                epd[c] = (ms[c] == 2);
            end
            chk("R10 model", pu_en, epu, pd_en, epd);
            pat_b = pu_en & pd_en;
            checks++;
            if (pat_b != '0) begin
                errors++;
                $display("FAIL R7 code 11: %h exp %h", pat_b, {N{1'b0}});
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule